// File: doc/BRIEF.md
# Word-at-a-time bus-stealing DMA engine

This block copies a run of words from one address range to another without the processor touching each word. Software loads a source address, a destination address and a word count into the block's registers, then sets a start bit. From then on the engine works alone. It holds the shared memory bus for only one word at a time. For each word it raises a bus request and waits for the grant. It then reads the source word and writes that word to the destination, and gives the bus back before it asks again. The processor can therefore keep fetching and executing between words.

Each of the two addresses moves up by one word after every copy. Either one can instead be pinned, so the engine can drain a device's data port into memory or fill a device port from memory. When the count runs out, a sticky interrupt line rises and stays high until software clears it. A status word shows whether a run is in progress. While a run is in progress, the engine refuses every register write except the interrupt clear.

Top module: `steal_dma`

## Requirements
- R1: After reset, `bus_req`, `mem_rd`, `mem_wr`, `busy` and `irq` are low, and the register readbacks at offsets 0 (source), 2 (count) and 5 (status) read zero.
- R2: While idle, a write to offset 0, 1 or 2 loads the source address, the destination address or the word count. The value written reads back at the same offset.
- R3: For each word, the engine raises `bus_req` and waits for `bus_gnt`. Only then does it assert `mem_rd` at the source address, and after that `mem_wr` at the destination address with the word just read. No memory strobe is ever asserted without the grant, and `mem_rd` and `mem_wr` are never high together.
- R4: `bus_req` is low in the cycle after the write's `mem_ready`. It stays low for at least one cycle before the next word is requested, so a run of N words shows exactly N separate request pulses.
- R5: After each word, the source and destination addresses each increase by one. Bit 1 of the control register (offset 3) pins the source address and bit 2 pins the destination address. Offsets 0 and 1 read back the current addresses.
- R6: The count register decreases by one per word copied and reads back as zero when a run has ended.
- R7: When the last word's bus release is done, `irq` rises and `busy` falls. `irq` stays high until a write to offset 4 with bit 0 set.
- R8: Writing bit 0 of the control register (the start bit) while the count is zero raises `irq` at that write's clock edge. No bus request or memory strobe follows.
- R9: While `busy` is high, writes to offsets 0 to 3 have no effect, including a new start. The interrupt clear at offset 4 still acts.
- R10: `busy` is high from the clock edge of the start write until the run ends. The status word at offset 5 shows `busy` in bit 0 and `irq` in bit 1.
- R11: While `mem_ready` is low, the asserted strobe and `mem_addr` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and readback |
| reg_wdata | input | RW | Register write data |
| reg_rdata | output | RW | Readback of the register at `reg_addr` |
| busy | output | 1 | Run in progress |
| irq | output | 1 | Sticky completion interrupt |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_addr | output | AW | Memory word address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ready | input | 1 | Memory access complete |

## Verification
The copy is run with both addresses advancing, with the source pinned and with the destination pinned. Each of these leaves a different pattern in the destination memory, so a wrong hold bit or a wrong increment shows up in the stored data. The same copy is then repeated with late grants and with memory wait states, which separates correct waiting for the handshake from cycle-count assumptions. A zero count, writes made during a run and an interrupt clear made during a run each test one edge of the control logic. Counting request pulses shows whether the bus is released after every word or held for a burst.

// File: rtl/steal_dma_pkg.sv
package steal_dma_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_RD,
    ST_WR,
    ST_REL
  } seq_state_e;

  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] OFS_SRC  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_DST  = 3'd1;
  localparam logic [REG_AW-1:0] OFS_CNT  = 3'd2;
  localparam logic [REG_AW-1:0] OFS_CTRL = 3'd3;
  localparam logic [REG_AW-1:0] OFS_ICLR = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STAT = 3'd5;

  localparam int CTRL_GO       = 0;
  localparam int CTRL_SRC_HOLD = 1;
  localparam int CTRL_DST_HOLD = 2;

  localparam int NUM_CHAN = 2;
  localparam int CH_SRC   = 0;
  localparam int CH_DST   = 1;

endpackage

// File: rtl/steal_dma_addr_chan.sv
module steal_dma_addr_chan #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  input  logic          step_en,
  input  logic          hold,
  output logic [AW-1:0] addr_q
);

  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_d  = addr_q;
    addr_en = 1'b0;
    if (load_en) begin
      addr_d  = load_val;
      addr_en = 1'b1;
    end else if (step_en && !hold) begin
      addr_d  = addr_q + 1'b1;
      addr_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

endmodule

// File: rtl/steal_dma_counter.sv
module steal_dma_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  input  logic          dec_en,
  output logic [CW-1:0] cnt_q,
  output logic          is_zero
);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load_en) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (dec_en && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/steal_dma_seq.sv
module steal_dma_seq
  import steal_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic bus_gnt,
  input  logic mem_ready,
  input  logic cnt_zero,
  output logic bus_req,
  output logic rd_en,
  output logic wr_en,
  output logic cap_en,
  output logic step_en,
  output logic done,
  output logic busy
);

  seq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go)        st_d = ST_REQ;
      ST_REQ:  if (bus_gnt)   st_d = ST_RD;
      ST_RD:   if (mem_ready) st_d = ST_WR;
      ST_WR:   if (mem_ready) st_d = ST_REL;
      ST_REL:  st_d = cnt_zero ? ST_IDLE : ST_REQ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign bus_req = (st_q == ST_REQ) || (st_q == ST_RD) || (st_q == ST_WR);
  assign rd_en   = (st_q == ST_RD);
  assign wr_en   = (st_q == ST_WR);
  assign cap_en  = rd_en && mem_ready;
  assign step_en = wr_en && mem_ready;
  assign done    = (st_q == ST_REL) && cnt_zero;
  assign busy    = (st_q != ST_IDLE);

endmodule

// File: rtl/steal_dma.sv
module steal_dma
  import steal_dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [RW-1:0]     reg_wdata,
  output logic [RW-1:0]     reg_rdata,
  output logic              busy,
  output logic              irq,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [AW-1:0]     mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DW-1:0]     mem_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              mem_ready
);

  localparam int PAD_A = RW - AW;
  localparam int PAD_C = RW - CW;

  logic              wr_open;
  logic              go_wr, go_run, go_empty;
  logic              ctrl_we;
  logic              src_hold_q, dst_hold_q;
  logic              cnt_zero, cap_en, step_en, done;
  logic              irq_set, irq_clr, irq_d;
  logic [CW-1:0]     cnt_q;
  logic [DW-1:0]     buf_q;
  logic [NUM_CHAN-1:0] ch_load, ch_hold;
  logic [AW-1:0]     ch_addr [NUM_CHAN];
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata;

  // register writes are accepted only while idle; interrupt clear always
  assign wr_open  = reg_we && !busy;
  assign ctrl_we  = wr_open && (reg_addr == OFS_CTRL);
  assign go_wr    = ctrl_we && reg_wdata[CTRL_GO];
  assign go_run   = go_wr && !cnt_zero;
  assign go_empty = go_wr && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_hold_q <= 1'b0;
      dst_hold_q <= 1'b0;
    end else if (ctrl_we) begin
      src_hold_q <= reg_wdata[CTRL_SRC_HOLD];
      dst_hold_q <= reg_wdata[CTRL_DST_HOLD];
    end
  end

  assign ch_load[CH_SRC] = wr_open && (reg_addr == OFS_SRC);
  assign ch_load[CH_DST] = wr_open && (reg_addr == OFS_DST);
  assign ch_hold[CH_SRC] = src_hold_q;
  assign ch_hold[CH_DST] = dst_hold_q;

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    steal_dma_addr_chan #(.AW(AW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (ch_load[g]),
      .load_val (reg_wdata[AW-1:0]),
      .step_en  (step_en),
      .hold     (ch_hold[g]),
      .addr_q   (ch_addr[g])
    );
  end

  steal_dma_counter #(.CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (wr_open && (reg_addr == OFS_CNT)),
    .load_val (reg_wdata[CW-1:0]),
    .dec_en   (step_en),
    .cnt_q    (cnt_q),
    .is_zero  (cnt_zero)
  );

  steal_dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_run),
    .bus_gnt   (bus_gnt),
    .mem_ready (mem_ready),
    .cnt_zero  (cnt_zero),
    .bus_req   (bus_req),
    .rd_en     (mem_rd),
    .wr_en     (mem_wr),
    .cap_en    (cap_en),
    .step_en   (step_en),
    .done      (done),
    .busy      (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
    end else if (cap_en) begin
      buf_q <= mem_rdata;
    end
  end

  assign mem_addr  = mem_wr ? ch_addr[CH_DST] : ch_addr[CH_SRC];
  assign mem_wdata = buf_q;

  // completion flag: set wins over clear
  assign irq_set = done || go_empty;
  assign irq_clr = reg_we && (reg_addr == OFS_ICLR) && reg_wdata[0];

  always_comb begin
    irq_d = irq;
    if (irq_set)      irq_d = 1'b1;
    else if (irq_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= irq_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_SRC:  reg_rdata = {{PAD_A{1'b0}}, ch_addr[CH_SRC]};
      OFS_DST:  reg_rdata = {{PAD_A{1'b0}}, ch_addr[CH_DST]};
      OFS_CNT:  reg_rdata = {{PAD_C{1'b0}}, cnt_q};
      OFS_CTRL: begin
        reg_rdata[CTRL_SRC_HOLD] = src_hold_q;
        reg_rdata[CTRL_DST_HOLD] = dst_hold_q;
      end
      OFS_STAT: reg_rdata[1:0] = {irq, busy};
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/steal_dma_chk.sv
module steal_dma_chk
  import steal_dma_pkg::*;
#(
  parameter int AW = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [REG_AW-1:0] reg_addr,
  input logic              clr_bit,
  input logic              busy,
  input logic              irq,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [AW-1:0]     mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              mem_ready
);

  a_r3_strobe_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || mem_wr) |-> bus_gnt);

  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r4_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_ready) |=> (!bus_req && !mem_rd && !mem_wr));

  a_r10_idle_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_req && !mem_rd && !mem_wr));

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_we && (reg_addr == OFS_ICLR) && clr_bit)) |=> irq);

  a_r11_read_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ready) |=> (mem_rd && $stable(mem_addr)));

  a_r11_write_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && !mem_ready) |=> (mem_wr && $stable(mem_addr)));

endmodule

bind steal_dma steal_dma_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .clr_bit   (reg_wdata[0]),
  .busy      (busy),
  .irq       (irq),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .mem_addr  (mem_addr),
  .mem_rd    (mem_rd),
  .mem_wr    (mem_wr),
  .mem_ready (mem_ready)
);

// File: tb/steal_dma_tb_top.sv
module steal_dma_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int RW = 32;

  logic          clk;
  logic          rst_n;
  logic          reg_we;
  logic [2:0]    reg_addr;
  logic [RW-1:0] reg_wdata;
  logic [RW-1:0] reg_rdata;
  logic          busy, irq, bus_req, bus_gnt;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr, mem_ready;
  logic [DW-1:0] mem_wdata, mem_rdata;

  int tests_run = 0;
  int tests_failed = 0;
  int req_rises = 0;
  int no_gnt_hits = 0;
  int wait_n = 0;
  int gnt_lat = 0;
  int wcnt = 0;
  int gcnt = 0;
  int cycles = 0;
  logic req_prev = 1'b0;
  logic [DW-1:0] mem [256];

  steal_dma #(.AW(AW), .DW(DW), .CW(16), .RW(RW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .irq(irq),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // memory and arbiter models
  assign mem_ready = (mem_rd || mem_wr) && (wcnt == wait_n);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if ((mem_rd || mem_wr) && !mem_ready) wcnt <= wcnt + 1;
    else wcnt <= 0;
    if (mem_wr && mem_ready) mem[mem_addr[7:0]] <= mem_wdata;
    if (bus_req && !bus_gnt) gcnt <= gcnt + 1;
    else gcnt <= 0;
    if (!rst_n) bus_gnt <= 1'b0;
    else bus_gnt <= bus_req && (bus_gnt || gcnt >= gnt_lat);
    req_prev <= bus_req;
    if (bus_req && !req_prev) req_rises <= req_rises + 1;
    if ((mem_rd || mem_wr) && !bus_gnt) no_gnt_hits <= no_gnt_hits + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_done(input string tag);
    int n;
    n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check({tag, " run ended"}, {31'd0, busy}, 32'd0);
  endtask

  task automatic start_run(input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] n, input logic [2:0] holds);
    reg_write(3'd0, {16'd0, s});
    reg_write(3'd1, {16'd0, d});
    reg_write(3'd2, {16'd0, n});
    reg_write(3'd3, {29'd0, holds[2:1], 1'b1});
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 bus_req", {31'd0, bus_req}, 32'd0);
    check("R1 strobes", {30'd0, mem_rd, mem_wr}, 32'd0);
    check("R1 busy/irq", {30'd0, busy, irq}, 32'd0);
    reg_read(3'd0, v); check("R1 src readback", v, 32'd0);
    reg_read(3'd2, v); check("R1 count readback", v, 32'd0);
    reg_read(3'd5, v); check("R1 status", v, 32'd0);
  endtask

  task automatic t_program();
    logic [31:0] v;
    reg_write(3'd0, 32'h0010);
    reg_write(3'd1, 32'h0040);
    reg_write(3'd2, 32'h0005);
    reg_read(3'd0, v); check("R2 src", v, 32'h0010);
    reg_read(3'd1, v); check("R2 dst", v, 32'h0040);
    reg_read(3'd2, v); check("R2 count", v, 32'h0005);
  endtask

  task automatic t_copy_inc();
    logic [31:0] v;
    int r0;
    for (int i = 0; i < 4; i++) mem[8'h10 + i] = 16'hA000 + 16'(i);
    r0 = req_rises;
    start_run(16'h0010, 16'h0040, 16'd4, 3'b000);
    check("R10 busy after start", {31'd0, busy}, 32'd1);
    reg_read(3'd5, v); check("R10 status busy bit", {31'd0, v[0]}, 32'd1);
    wait_done("R7");
    for (int i = 0; i < 4; i++)
      check("R3 copied word", {16'd0, mem[8'h40 + i]}, 32'hA000 + i);
    check("R4 request pulses", req_rises - r0, 4);
    check("R3 no strobe without grant", no_gnt_hits, 0);
    reg_read(3'd0, v); check("R5 src advanced", v, 32'h0014);
    reg_read(3'd1, v); check("R5 dst advanced", v, 32'h0044);
    reg_read(3'd2, v); check("R6 count drained", v, 32'd0);
    check("R7 irq raised", {31'd0, irq}, 32'd1);
    reg_read(3'd5, v); check("R10 status irq only", v, 32'd2);
    repeat (5) @(negedge clk);
    check("R7 irq stays", {31'd0, irq}, 32'd1);
    reg_write(3'd4, 32'd1);
    check("R7 irq cleared", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_fixed_src();
    logic [31:0] v;
    mem[8'h20] = 16'h5A5A;
    start_run(16'h0020, 16'h0060, 16'd3, 3'b010);
    wait_done("R5 src hold");
    for (int i = 0; i < 3; i++)
      check("R5 port word", {16'd0, mem[8'h60 + i]}, 32'h5A5A);
    reg_read(3'd0, v); check("R5 src pinned", v, 32'h0020);
    reg_read(3'd1, v); check("R5 dst moved", v, 32'h0063);
    reg_write(3'd4, 32'd1);
  endtask

  task automatic t_fixed_dst();
    logic [31:0] v;
    for (int i = 0; i < 3; i++) mem[8'h30 + i] = 16'hC000 + 16'(i);
    mem[8'h71] = 16'h0000;
    start_run(16'h0030, 16'h0070, 16'd3, 3'b100);
    wait_done("R5 dst hold");
    check("R5 port got last word", {16'd0, mem[8'h70]}, 32'hC002);
    check("R5 next word untouched", {16'd0, mem[8'h71]}, 32'h0000);
    reg_read(3'd1, v); check("R5 dst pinned", v, 32'h0070);
    reg_write(3'd4, 32'd1);
  endtask

  task automatic t_waits();
    wait_n = 2; gnt_lat = 3;
    mem[8'h80] = 16'h1234; mem[8'h81] = 16'h5678;
    start_run(16'h0080, 16'h0090, 16'd2, 3'b000);
    wait_done("R11");
    check("R11 word0 under waits", {16'd0, mem[8'h90]}, 32'h1234);
    check("R11 word1 under waits", {16'd0, mem[8'h91]}, 32'h5678);
    check("R3 grant respected", no_gnt_hits, 0);
    wait_n = 0; gnt_lat = 0;
    reg_write(3'd4, 32'd1);
  endtask

  task automatic t_zero();
    int r0;
    r0 = req_rises;
    reg_write(3'd2, 32'd0);
    reg_write(3'd3, 32'd1);
    check("R8 irq at once", {31'd0, irq}, 32'd1);
    check("R8 not busy", {31'd0, busy}, 32'd0);
    repeat (4) @(negedge clk);
    check("R8 no bus request", req_rises - r0, 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    gnt_lat = 6;
    for (int i = 0; i < 3; i++) mem[8'hA0 + i] = 16'h7700 + 16'(i);
    start_run(16'h00A0, 16'h00B0, 16'd3, 3'b000);
    check("R9 irq still set from earlier", {31'd0, irq}, 32'd1);
    reg_write(3'd4, 32'd1);
    check("R9 clear works while busy", {30'd0, busy, irq}, 32'd2);
    reg_write(3'd0, 32'h0099);
    reg_write(3'd2, 32'h0077);
    reg_write(3'd3, 32'h0007);
    wait_done("R9");
    gnt_lat = 0;
    reg_read(3'd0, v); check("R9 src write ignored", v, 32'h00A3);
    reg_read(3'd2, v); check("R9 count write ignored", v, 32'd0);
    reg_read(3'd3, v); check("R9 ctrl write ignored", v, 32'd0);
    check("R9 data intact", {16'd0, mem[8'hB2]}, 32'h7702);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_copy_inc();
    t_fixed_src();
    t_fixed_dst();
    t_waits();
    t_zero();
    t_busy_ignore();
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      tests_run++;
      tests_failed++;
      $display("FAIL R7 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule